// File: doc/BRIEF.md
# Mode-Dependent Multiplexed Port Controller

This block governs a 16-pin port in which each pin serves either as a line of the external data bus or as a general-purpose I/O pin. The operating mode of the chip decides the split: in some modes the assignment is fixed, and in one mode a per-pin function-control register picks it. A second register holds the per-pin direction. That direction applies only while a pin acts as general I/O.

Both registers sit on a simple register bus with a one-bit register select. Each returns its contents combinationally on the read data output. For every pin the block computes a bus-function flag, an output enable and an output value. It also produces the value that software sees when it reads the general-I/O data: the output latch for pins driven as outputs, and the sampled pad level for all other pins.

Two events clear state apart from the main reset. A watchdog-sourced reset pulse clears only the function-control register and leaves the direction register as it was. Hardware standby clears both registers for as long as it is held. Sleep and software standby need no input, because neither of them changes the registers.

Top module: `muxport_ctrl`

## Requirements
- R1: While `rst_n` is low, both the direction register and the function-control register read back as 0x0000.
- R2: A write with `reg_wr_i` high stores `reg_wdata_i` into the direction register when `reg_sel_i` is 0 and into the function-control register when `reg_sel_i` is 1. Every bit can be written and read. The new value appears on `reg_rdata_o` from the clock edge that takes the write.
- R3: A one-cycle `wdt_rst_i` pulse clears the function-control register and leaves the direction register unchanged.
- R4: While `hw_standby_i` is high, both registers are cleared and register writes have no effect.
- R5: With `mode_i` = 2'b00 (external bus, internal ROM off, 8-bit bus), pins 0 to 7 are data bus pins and pins 8 to 15 are general I/O. The function-control register has no effect.
- R6: With `mode_i` = 2'b01 (external bus, internal ROM off, 16-bit bus), all 16 pins are data bus pins. The function-control register has no effect.
- R7: With `mode_i` = 2'b10 (external bus with internal ROM on), a pin is a data bus pin when its function-control bit is 1 and general I/O when the bit is 0.
- R8: With `mode_i` = 2'b11 (single-chip), all pins are general I/O. The function-control register has no effect.
- R9: A general-I/O pin is enabled as an output exactly when its direction bit is 1, and it drives the corresponding `gpio_out_i` bit.
- R10: A data bus pin ignores its direction bit. It is enabled as an output exactly when `bus_we_i` is high, and it drives the corresponding `bus_wdata_i` bit.
- R11: Each bit of `gpio_rd_o` equals the `gpio_out_i` bit for a general-I/O pin whose direction bit is 1. For every other pin it equals the `pad_in_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_rst_i | input | 1 | Watchdog-sourced reset pulse |
| hw_standby_i | input | 1 | Hardware standby active |
| mode_i | input | 2 | Operating mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 direction, 1 function control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register contents |
| bus_we_i | input | 1 | External bus write strobe |
| bus_wdata_i | input | 16 | External bus write data |
| gpio_out_i | input | 16 | General-I/O output latch |
| pad_in_i | input | 16 | Sampled pad levels |
| bus_sel_o | output | 16 | Per-pin data bus function flag |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_out_o | output | 16 | Per-pin output value |
| gpio_rd_o | output | 16 | General-I/O read data |

## Verification
The only internal state is the pair of registers, so any corrupted bit appears on `reg_rdata_o` as soon as that register is selected, in the same cycle. It also appears on the pad outputs of the affected pin, and it does so combinationally. A wrong direction bit in single-chip mode turns the pin's output enable on or off at once. In the ROM-enabled mode, a wrong control bit flips that pin between driving `bus_wdata_i` and driving `gpio_out_i`. A reset rule applied to the wrong register is visible on the first read after the `wdt_rst_i` pulse or after standby.

// File: rtl/muxport_pkg.sv
package muxport_pkg;

    typedef enum logic [1:0] {
        MODE_EXT8   = 2'b00,
        MODE_EXT16  = 2'b01,
        MODE_EXTROM = 2'b10,
        MODE_SINGLE = 2'b11
    } port_mode_e;

    localparam logic SEL_DIR = 1'b0;
    localparam logic SEL_FNC = 1'b1;

endpackage

// File: rtl/muxport_regs.sv
module muxport_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wdt_rst_i,
    input  logic         hw_standby_i,
    input  logic         reg_wr_i,
    input  logic         reg_sel_i,
    input  logic [W-1:0] reg_wdata_i,
    output logic [W-1:0] reg_rdata_o,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] fnc_o
);
    import muxport_pkg::*;

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] fnc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hw_standby_i) begin
            r_d.dir = '0;
            r_d.fnc = '0;
        end else begin
            if (reg_wr_i && reg_sel_i == SEL_DIR) r_d.dir = reg_wdata_i;
            if (reg_wr_i && reg_sel_i == SEL_FNC) r_d.fnc = reg_wdata_i;
            if (wdt_rst_i)                         r_d.fnc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_o       = r_q.dir;
    assign fnc_o       = r_q.fnc;
    assign reg_rdata_o = (reg_sel_i == SEL_FNC) ? r_q.fnc : r_q.dir;

endmodule

// File: rtl/muxport_fnsel.sv
module muxport_fnsel #(
    parameter int W      = 16,
    parameter int LOW_W  = 8
) (
    input  muxport_pkg::port_mode_e mode_i,
    input  logic [W-1:0]            fnc_i,
    output logic [W-1:0]            bus_sel_o
);
    import muxport_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam logic IN_LOW = (i < LOW_W);
        always_comb begin
            case (mode_i)
                MODE_EXT8:   bus_sel_o[i] = IN_LOW;
                MODE_EXT16:  bus_sel_o[i] = 1'b1;
                MODE_EXTROM: bus_sel_o[i] = fnc_i[i];
                default:     bus_sel_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/muxport_pin.sv
module muxport_pin (
    input  logic bus_sel_i,
    input  logic dir_i,
    input  logic bus_we_i,
    input  logic bus_wdata_i,
    input  logic gpio_out_i,
    input  logic pad_in_i,
    output logic pad_oe_o,
    output logic pad_out_o,
    output logic gpio_rd_o
);
    logic drive_gpio;

    always_comb begin
        drive_gpio = !bus_sel_i && dir_i;
        pad_oe_o   = bus_sel_i ? bus_we_i    : dir_i;
        pad_out_o  = bus_sel_i ? bus_wdata_i : gpio_out_i;
        gpio_rd_o  = drive_gpio ? gpio_out_i : pad_in_i;
    end

endmodule

// File: rtl/muxport_ctrl.sv
module muxport_ctrl #(
    parameter int W     = 16,
    parameter int LOW_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wdt_rst_i,
    input  logic         hw_standby_i,
    input  logic [1:0]   mode_i,
    input  logic         reg_wr_i,
    input  logic         reg_sel_i,
    input  logic [W-1:0] reg_wdata_i,
    output logic [W-1:0] reg_rdata_o,
    input  logic         bus_we_i,
    input  logic [W-1:0] bus_wdata_i,
    input  logic [W-1:0] gpio_out_i,
    input  logic [W-1:0] pad_in_i,
    output logic [W-1:0] bus_sel_o,
    output logic [W-1:0] pad_oe_o,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] gpio_rd_o
);
    import muxport_pkg::*;

    logic [W-1:0] dir_val;
    logic [W-1:0] fnc_val;
    port_mode_e   mode_e;

    assign mode_e = port_mode_e'(mode_i);

    muxport_regs #(.W(W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdt_rst_i    (wdt_rst_i),
        .hw_standby_i (hw_standby_i),
        .reg_wr_i     (reg_wr_i),
        .reg_sel_i    (reg_sel_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .dir_o        (dir_val),
        .fnc_o        (fnc_val)
    );

    muxport_fnsel #(.W(W), .LOW_W(LOW_W)) i_fnsel (
        .mode_i    (mode_e),
        .fnc_i     (fnc_val),
        .bus_sel_o (bus_sel_o)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        muxport_pin i_pin (
            .bus_sel_i   (bus_sel_o[i]),
            .dir_i       (dir_val[i]),
            .bus_we_i    (bus_we_i),
            .bus_wdata_i (bus_wdata_i[i]),
            .gpio_out_i  (gpio_out_i[i]),
            .pad_in_i    (pad_in_i[i]),
            .pad_oe_o    (pad_oe_o[i]),
            .pad_out_o   (pad_out_o[i]),
            .gpio_rd_o   (gpio_rd_o[i])
        );
    end

endmodule

// File: rtl/muxport_ctrl_chk.sv
module muxport_ctrl_chk #(
    parameter int W     = 16,
    parameter int LOW_W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wdt_rst_i,
    input logic         hw_standby_i,
    input logic [1:0]   mode_i,
    input logic         reg_wr_i,
    input logic         reg_sel_i,
    input logic [W-1:0] reg_wdata_i,
    input logic         bus_we_i,
    input logic [W-1:0] bus_wdata_i,
    input logic [W-1:0] gpio_out_i,
    input logic [W-1:0] bus_sel_o,
    input logic [W-1:0] pad_oe_o,
    input logic [W-1:0] pad_out_o,
    input logic [W-1:0] dir_val,
    input logic [W-1:0] fnc_val
);
    localparam logic [W-1:0] LOW_MASK = (W'(1) << LOW_W) - W'(1);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && !hw_standby_i) |=> dir_val == $past(reg_wdata_i));

    p_wdt_keeps_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_i && !hw_standby_i && !(reg_wr_i && !reg_sel_i)) |=> dir_val == $past(dir_val));

    p_wdt_clears_fnc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_i |=> fnc_val == '0);

    p_standby_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby_i |=> (dir_val == '0 && fnc_val == '0));

    p_ext8_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> bus_sel_o == LOW_MASK);

    p_ext16_all_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (&bus_sel_o));

    p_rom_follows_fnc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> bus_sel_o == fnc_val);

    p_single_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> bus_sel_o == '0);

    p_single_oe_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> (pad_oe_o == dir_val && pad_out_o == gpio_out_i));

    p_ext16_bus_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (pad_oe_o == {W{bus_we_i}} && pad_out_o == bus_wdata_i));

endmodule

bind muxport_ctrl muxport_ctrl_chk #(.W(W), .LOW_W(LOW_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_rst_i    (wdt_rst_i),
    .hw_standby_i (hw_standby_i),
    .mode_i       (mode_i),
    .reg_wr_i     (reg_wr_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .bus_we_i     (bus_we_i),
    .bus_wdata_i  (bus_wdata_i),
    .gpio_out_i   (gpio_out_i),
    .bus_sel_o    (bus_sel_o),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .dir_val      (dir_val),
    .fnc_val      (fnc_val)
);

// File: tb/test_muxport_ctrl.sv
module test_muxport_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst_i = 1'b0;
    logic        hw_standby_i = 1'b0;
    logic [1:0]  mode_i = 2'b11;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        bus_we_i = 1'b0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] gpio_out_i = '0;
    logic [15:0] pad_in_i = '0;
    logic [15:0] bus_sel_o, pad_oe_o, pad_out_o, gpio_rd_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    muxport_ctrl i_muxport_ctrl (
        .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst_i), .hw_standby_i(hw_standby_i),
        .mode_i(mode_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .gpio_out_i(gpio_out_i), .pad_in_i(pad_in_i),
        .bus_sel_o(bus_sel_o), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
        .gpio_rd_o(gpio_rd_o)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        @(negedge clk);
        reg_sel_i = sel; reg_wdata_i = val; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] val);
        reg_sel_i = sel;
        #1 val = reg_rdata_o;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd_reg(1'b0, v); chk("R1 dir after reset", v, 16'h0000);
        rd_reg(1'b1, v); chk("R1 fnc after reset", v, 16'h0000);
        wr_reg(1'b0, 16'hBEEF); wr_reg(1'b1, 16'hCAFE);
        @(negedge clk); rst_n = 1'b0; #2;
        rd_reg(1'b0, v); chk("R1 dir cleared by rst_n", v, 16'h0000);
        rd_reg(1'b1, v); chk("R1 fnc cleared by rst_n", v, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_rw;
        logic [15:0] v;
        wr_reg(1'b0, 16'hA5C3); wr_reg(1'b1, 16'h5A3C);
        rd_reg(1'b0, v); chk("R2 dir readback", v, 16'hA5C3);
        rd_reg(1'b1, v); chk("R2 fnc readback", v, 16'h5A3C);
        wr_reg(1'b0, 16'hFFFF); wr_reg(1'b1, 16'h0000);
        rd_reg(1'b0, v); chk("R2 dir all ones", v, 16'hFFFF);
        rd_reg(1'b1, v); chk("R2 fnc all zeros", v, 16'h0000);
    endtask

    task automatic t_wdt;
        logic [15:0] v;
        wr_reg(1'b0, 16'h1234); wr_reg(1'b1, 16'hABCD);
        @(negedge clk); wdt_rst_i = 1'b1;
        @(negedge clk); wdt_rst_i = 1'b0;
        rd_reg(1'b0, v); chk("R3 dir kept over watchdog reset", v, 16'h1234);
        rd_reg(1'b1, v); chk("R3 fnc cleared by watchdog reset", v, 16'h0000);
    endtask

    task automatic t_standby;
        logic [15:0] v;
        wr_reg(1'b0, 16'hFFFF); wr_reg(1'b1, 16'hFFFF);
        @(negedge clk); hw_standby_i = 1'b1;
        @(negedge clk);
        rd_reg(1'b0, v); chk("R4 dir cleared in standby", v, 16'h0000);
        rd_reg(1'b1, v); chk("R4 fnc cleared in standby", v, 16'h0000);
        wr_reg(1'b0, 16'h00FF);
        rd_reg(1'b0, v); chk("R4 write ignored in standby", v, 16'h0000);
        @(negedge clk); hw_standby_i = 1'b0;
    endtask

    task automatic setup_pins;
        wr_reg(1'b0, 16'h0F0F); wr_reg(1'b1, 16'h3C3C);
        gpio_out_i = 16'hAAAA; bus_wdata_i = 16'h5555; pad_in_i = 16'h9696; bus_we_i = 1'b0;
    endtask

    task automatic t_ext8;
        setup_pins(); mode_i = 2'b00; #1;
        chk("R5 ext8 bus_sel", bus_sel_o, 16'h00FF);
        chk("R9 ext8 oe, bus idle", pad_oe_o, 16'h0F00);
        chk("R5 ext8 pad_out", pad_out_o, 16'hAA55);
        bus_we_i = 1'b1; #1;
        chk("R10 ext8 oe, bus write", pad_oe_o, 16'h0FFF);
        bus_we_i = 1'b0;
    endtask

    task automatic t_ext16;
        mode_i = 2'b01; #1;
        chk("R6 ext16 bus_sel", bus_sel_o, 16'hFFFF);
        chk("R10 ext16 oe idle ignores dir", pad_oe_o, 16'h0000);
        chk("R11 ext16 gpio_rd is pad", gpio_rd_o, 16'h9696);
        bus_we_i = 1'b1; #1;
        chk("R10 ext16 oe write", pad_oe_o, 16'hFFFF);
        chk("R10 ext16 pad_out", pad_out_o, 16'h5555);
        bus_we_i = 1'b0;
    endtask

    task automatic t_rom;
        mode_i = 2'b10; bus_we_i = 1'b1; #1;
        chk("R7 rom bus_sel", bus_sel_o, 16'h3C3C);
        chk("R7 rom oe", pad_oe_o, 16'h3F3F);
        chk("R7 rom pad_out", pad_out_o, 16'h9696);
        bus_we_i = 1'b0;
        wr_reg(1'b1, 16'hF000); #1;
        chk("R7 rom bus_sel after fnc change", bus_sel_o, 16'hF000);
    endtask

    task automatic t_single;
        mode_i = 2'b11; bus_we_i = 1'b1; #1;
        chk("R8 single bus_sel", bus_sel_o, 16'h0000);
        chk("R9 single oe", pad_oe_o, 16'h0F0F);
        chk("R9 single pad_out", pad_out_o, 16'hAAAA);
        chk("R11 single gpio_rd", gpio_rd_o, 16'h9A9A);
        bus_we_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_wdt();
        t_standby();
        t_ext8();
        t_ext16();
        t_rom();
        t_single();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule